// File: doc/BRIEF.md
# Video Memory Indirect Access Port

This block lets a CPU reach a 16 KB video memory through just two register slots. One slot is the address register and the other is the data register. The address register is 14 bits wide. Software loads it with two byte writes to the address slot: the upper part goes first and the lower byte second. A write toggle records which half comes next. Each access to the data slot acts on video memory at the current address, and the address then advances by one.

Writes go straight through to memory. Reads go through a one-deep buffer. A read returns whatever the buffer holds and, in the same cycle, starts a fetch of the byte at the current address to refill the buffer. The first data read after an address load therefore returns stale data, and software throws it away.

The video RAM is synchronous with one cycle of read latency. When a fetch returns in the cycle right after it was issued, a forward path presents it straight away, so reads on consecutive cycles still return the right bytes.

Top module: `vram_port`

## Requirements
- R1: After reset the address register is 0x0000, the write toggle points at the high half, and `rdata` reads 0x00.
- R2: With the toggle clear, an address-slot write (`reg_sel`=1, `reg_idx`=0, `wr_stb`=1) loads `wdata[5:0]` into address bits 13:8, drops `wdata[7:6]` and sets the toggle. With the toggle set, it loads `wdata` into address bits 7:0 and clears the toggle.
- R3: A pulse on `stat_clr` clears the write toggle, so the next address-slot write is taken as the high half. If it coincides with an address write, the clear wins.
- R4: A data-slot write (`reg_sel`=1, `reg_idx`=1, `wr_stb`=1) drives `mem_we`=1, `mem_addr` equal to the current address and `mem_wdata`=`wdata` in the same cycle. The address then becomes address+1.
- R5: During a data-slot read (`reg_sel`=1, `reg_idx`=1, `rd_stb`=1, `wr_stb`=0), `rdata` shows the buffer contents. `mem_re`=1 with `mem_addr` equal to the current address, and the address then becomes address+1.
- R6: After an address load and a sequence of N bytes written from that address, reloading the address and reading N+1 times returns a stale first value, and read k (k>=2) returns byte k-1 of the sequence.
- R7: Incrementing the address from 0x3FFF gives 0x0000.
- R8: Data writes and address writes leave the read buffer unchanged.
- R9: Data reads on consecutive clock cycles each return the byte fetched by the read before them.
- R10: Strobes with `reg_sel`=0 have no effect: no memory access, and no change to the address, toggle or buffer.
- R11: `mem_we` and `mem_re` are never high together. When `wr_stb` and `rd_stb` are both high on the data slot, the access is a write.

Both strobes are single-cycle pulses. The read and write strobes are ignored for the address slot except as stated in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Selects this register pair |
| reg_idx | input | 1 | 0 = address slot, 1 = data slot |
| rd_stb | input | 1 | Read strobe, one cycle |
| wr_stb | input | 1 | Write strobe, one cycle |
| stat_clr | input | 1 | Clears the address write toggle |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data (read buffer view) |
| mem_addr | output | 14 | Video RAM address |
| mem_we | output | 1 | Video RAM write enable |
| mem_re | output | 1 | Video RAM read enable |
| mem_wdata | output | 8 | Video RAM write data |
| mem_rdata | input | 8 | Video RAM read data, one cycle after `mem_re` |

## Verification
The bench loads an address with the top bits of the high byte set. A design that failed to mask them would place the written bytes at the wrong location, and the read-back sequence would not match. It then writes a byte run, reloads the address and reads it back. A design without the buffer would return every byte one read early, and one whose writes touched the buffer would return a wrong stale value. Further tests check that back-to-back reads pick up the just-returned fetch, that the address rolls over at 0x3FFF to 0x0000 instead of into a fifteenth bit, that `stat_clr` resynchronises a half-loaded address, and that unselected strobes leave everything unchanged.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_ADDR  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_READ  = 2'd3
   } acc_e;
endpackage

// File: rtl/vram_decode.sv
module vram_decode
   import vram_port_pkg::*;
(
   input  logic reg_sel,
   input  logic reg_idx,
   input  logic rd_stb,
   input  logic wr_stb,
   output acc_e acc
);
   always_comb begin
      acc = ACC_NONE;
      if (reg_sel) begin
         if (!reg_idx) begin
            if (wr_stb) acc = ACC_ADDR;
         end else if (wr_stb) begin
            acc = ACC_WRITE;          // write wins over a simultaneous read
         end else if (rd_stb) begin
            acc = ACC_READ;
         end
      end
   end
endmodule

// File: rtl/vram_addr_latch.sv
module vram_addr_latch
   import vram_port_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  acc_e              acc,
   input  logic              clr_tog,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] addr,
   output logic              tog
);
   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_width
         $error("vram_addr_latch: ADDR_W must lie in (DATA_W, 2*DATA_W]");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic              tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         tog_q  <= 1'b0;
      end else begin
         unique case (acc)
            ACC_ADDR: begin
               if (!tog_q) addr_q[ADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
               else        addr_q[DATA_W-1:0]      <= wdata;
               tog_q <= ~tog_q;
            end
            ACC_WRITE, ACC_READ: addr_q <= addr_q + 1'b1;
            default: ;
         endcase
         if (clr_tog) tog_q <= 1'b0;
      end
   end

   assign addr = addr_q;
   assign tog  = tog_q;

   // R2: each address write flips the toggle unless a clear coincides
   p_tog_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_ADDR && !clr_tog) |=> (tog_q != $past(tog_q)));

   // R3: a clear always leaves the toggle at the high-half state
   p_tog_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_tog |=> !tog_q);

   // R4, R5, R7: data accesses step the address by one, modulo 2**ADDR_W
   p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_WRITE || acc == ACC_READ) |=>
         (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

   // R10: no access means the address holds
   p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_NONE) |=> $stable(addr_q));
endmodule

// File: rtl/vram_read_buf.sv
module vram_read_buf #(
   parameter int DATA_W = 8,
   parameter bit BYPASS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rdata
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("vram_read_buf: DATA_W must be positive");
      end
   endgenerate

   logic              pend_q;
   logic [DATA_W-1:0] buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         buf_q  <= '0;
      end else begin
         pend_q <= fetch;
         if (pend_q) buf_q <= mem_rdata;
      end
   end

   generate
      if (BYPASS) begin : g_forward
         // fetch result is visible in the cycle it returns
         assign rdata = pend_q ? mem_rdata : buf_q;
      end else begin : g_plain
         assign rdata = buf_q;
      end
   endgenerate

   // R8: the buffer changes only when a fetch returns
   p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q |=> $stable(buf_q));

   // R5: a returning fetch is captured into the buffer
   p_buf_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> (buf_q == $past(mem_rdata)));
endmodule

// File: rtl/vram_port.sv
module vram_port
   import vram_port_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 8,
   parameter bit BYPASS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_idx,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic              stat_clr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   acc_e              acc;
   logic [ADDR_W-1:0] cur_addr;
   logic              tog;

   vram_decode u_dec (
      .reg_sel (reg_sel),
      .reg_idx (reg_idx),
      .rd_stb  (rd_stb),
      .wr_stb  (wr_stb),
      .acc     (acc)
   );

   vram_addr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .clr_tog (stat_clr),
      .wdata   (wdata),
      .addr    (cur_addr),
      .tog     (tog)
   );

   vram_read_buf #(.DATA_W(DATA_W), .BYPASS(BYPASS)) u_rbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch     (acc == ACC_READ),
      .mem_rdata (mem_rdata),
      .rdata     (rdata)
   );

   assign mem_addr  = cur_addr;
   assign mem_we    = (acc == ACC_WRITE);
   assign mem_re    = (acc == ACC_READ);
   assign mem_wdata = wdata;

   // R11: never read and write the video RAM in one cycle
   p_we_re_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   // R10: an unselected cycle issues no memory access
   p_unsel_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> (!mem_we && !mem_re));

   // R2: the toggle changes only on address writes or clears
   p_tog_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(reg_sel && !reg_idx && wr_stb) && !stat_clr) |=> $stable(tog));
endmodule

// File: tb/vram_port_bench.sv
`timescale 1ns/1ps
module vram_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_idx = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
   logic        stat_clr = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [13:0] mem_addr;
   logic        mem_we, mem_re;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   vram_port u_vram_port (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_idx(reg_idx),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .stat_clr(stat_clr), .wdata(wdata),
      .rdata(rdata), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // synchronous video RAM, one-cycle read latency
   logic [7:0] vram [int];
   always @(posedge clk) begin
      if (mem_we) vram[int'(mem_addr)] = mem_wdata;
      if (mem_re) mem_rdata <= vram.exists(int'(mem_addr)) ? vram[int'(mem_addr)] : 8'h00;
   end

   // reference model built from the requirements
   logic [13:0] m_addr = '0;
   logic        m_tog  = 1'b0;
   logic [7:0]  m_buf  = '0;
   logic [7:0]  ref_mem [int];

   function automatic logic [7:0] ref_rd(input logic [13:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // one bus cycle; caller is at a falling edge
   task automatic bus(input bit sel, input bit idx, input bit rd, input bit wr,
                      input logic [7:0] wd, input string tag);
      reg_sel = sel; reg_idx = idx; rd_stb = rd; wr_stb = wr; wdata = wd;
      #1;
      if (sel && idx && wr) begin
         chk(mem_we === 1'b1 && mem_re === 1'b0, tag, {mem_we, mem_re}, 2'b10);
         chk(mem_addr === m_addr, tag, mem_addr, m_addr);
         chk(mem_wdata === wd, tag, mem_wdata, wd);
         ref_mem[int'(m_addr)] = wd;
         m_addr = m_addr + 1'b1;
      end else if (sel && idx && rd) begin
         chk(rdata === m_buf, tag, rdata, m_buf);
         chk(mem_re === 1'b1 && mem_addr === m_addr, tag, mem_addr, m_addr);
         m_buf  = ref_rd(m_addr);
         m_addr = m_addr + 1'b1;
      end else begin
         chk(mem_we === 1'b0 && mem_re === 1'b0, tag, {mem_we, mem_re}, 2'b00);
         if (sel && !idx && wr) begin
            if (!m_tog) m_addr[13:8] = wd[5:0];
            else        m_addr[7:0]  = wd;
            m_tog = ~m_tog;
         end
      end
      @(negedge clk);
      reg_sel = 0; reg_idx = 0; rd_stb = 0; wr_stb = 0; wdata = '0;
   endtask

   task automatic set_addr(input logic [13:0] a, input string tag);
      bus(1, 0, 0, 1, {2'b11, a[13:8]}, tag);   // top bits set to prove masking
      bus(1, 0, 0, 1, a[7:0], tag);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      #1;
      chk(rdata === 8'h00, "R1 rdata", rdata, 0);
      bus(1, 1, 0, 1, 8'h5A, "R1 first write at 0x0000");
   endtask

   task automatic t_sequence;
      set_addr(14'h0123, "R2 load");
      for (int i = 0; i < 5; i++) bus(1, 1, 0, 1, 8'hA0 + 8'(i), "R4 write seq");
      set_addr(14'h0123, "R2 reload");
      for (int i = 0; i < 6; i++) begin
         bus(1, 1, 1, 0, 8'h00, "R6 spaced read");
         idle(2);
      end
      // final fetched byte is unwritten (0x00); check one read shows it
      bus(1, 1, 1, 0, 8'h00, "R5 buffer view");
   endtask

   task automatic t_writes_keep_buf;
      set_addr(14'h0200, "R2 load");
      bus(1, 1, 0, 1, 8'h77, "R4 write");
      bus(1, 1, 1, 0, 8'h00, "R5 read prime");
      idle(2);
      set_addr(14'h0300, "R8 addr write");
      bus(1, 1, 0, 1, 8'h99, "R8 data write");
      bus(1, 1, 0, 1, 8'h98, "R8 data write");
      bus(1, 1, 1, 0, 8'h00, "R8 buffer kept");
      idle(2);
   endtask

   task automatic t_back_to_back;
      set_addr(14'h1000, "R2 load");
      for (int i = 0; i < 4; i++) bus(1, 1, 0, 1, 8'hC0 + 8'(i), "R4 write");
      set_addr(14'h1000, "R2 reload");
      for (int i = 0; i < 5; i++) bus(1, 1, 1, 0, 8'h00, "R9 back-to-back read");
      idle(2);
   endtask

   task automatic t_toggle_clear;
      bus(1, 0, 0, 1, 8'h3F, "R3 half load");
      stat_clr = 1'b1; m_tog = 1'b0;
      @(negedge clk);
      stat_clr = 1'b0;
      set_addr(14'h0456, "R3 load after clear");
      bus(1, 1, 0, 1, 8'h11, "R3 address after clear");
   endtask

   task automatic t_wrap;
      set_addr(14'h3FFF, "R7 load");
      bus(1, 1, 0, 1, 8'hE1, "R7 write at 0x3FFF");
      bus(1, 1, 0, 1, 8'hE2, "R7 write at 0x0000");
      set_addr(14'h3FFF, "R7 reload");
      bus(1, 1, 1, 0, 8'h00, "R7 read");
      idle(1);
      bus(1, 1, 1, 0, 8'h00, "R7 read");
      idle(1);
      bus(1, 1, 1, 0, 8'h00, "R7 read wrapped");
      idle(2);
   endtask

   task automatic t_unselected;
      set_addr(14'h0800, "R2 load");
      bus(0, 0, 0, 1, 8'h12, "R10 unselected addr write");
      bus(0, 1, 0, 1, 8'h34, "R10 unselected data write");
      bus(0, 1, 1, 0, 8'h00, "R10 unselected read");
      bus(1, 1, 0, 1, 8'h56, "R10 address unchanged");
      bus(1, 0, 0, 1, 8'h09, "R10 toggle unchanged");
      bus(1, 0, 0, 1, 8'h00, "R10 toggle unchanged");
      bus(1, 1, 0, 1, 8'h57, "R10 write after reload");
   endtask

   task automatic t_both_strobes;
      set_addr(14'h0A00, "R2 load");
      bus(1, 1, 1, 1, 8'h66, "R11 write wins");
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sequence();
      t_writes_keep_buf();
      t_back_to_back();
      t_toggle_clear();
      t_wrap();
      t_unselected();
      t_both_strobes();
      idle(2);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule